// File: doc/BRIEF.md
# Half-Duplex Handshake Packet Link Controller

This block is the host end of a byte-serial, half-duplex link to a peripheral controller. An external shift register moves the bytes. After each byte it returns a one-cycle done pulse and the byte it shifted in. The block owns the shift direction and the byte loads. It drives two handshake lines: a transfer-in-progress strobe, active low, and an acknowledge that toggles once per byte. It watches an active-low request line from the peer, which passes through a two-flop synchronizer. The peer releasing that line marks the end of an inbound frame.

The host offers an outbound packet through a valid/ready handshake. The packet carries a total byte count, where byte 0 is the type and the payload follows. The block fetches byte k by presenting index k and expecting the byte back combinationally. Inbound bytes come out one at a time with their payload index. A frame summary follows them: type, payload length and overflow flag.

When the peer starts talking in the middle of a write, the block abandons its packet and receives instead. It keeps the packet pending and sends it again from byte 0 after a turnaround delay. Both settle intervals are given in clock cycles.

Top module: `hslink_ctrl`

## Requirements
- R1: After reset the block holds `tx_ready` low and ignores `sr_done`. It runs a five-step start-up: lines idle (reset), `tip_n` low, `ack` toggled, `tip_n` high, lines idle. Each step is at least INIT_SETTLE cycles after the one before. Only after the last step does `tx_ready` rise.
- R2: While idle, `tip_n` and `ack` are both 1.
- R3: A pending send starts from idle only when the synchronized request is inactive (`peer_req_n`=1) and no settle delay is running. At the start, `sr_dir_out` goes to 1 and `sr_load` pulses with `tx_idx`=0 and `sr_load_data`=`tx_data`. At the same time `ack` goes to 1 and `tip_n` goes to 0.
- R4: While sending, each `sr_done` with the request inactive counts one byte. If bytes remain, `sr_load` pulses with the next index and `ack` toggles. After the byte count given by `tx_len`, `sr_dir_out` goes to 0, the lines return to idle and `tx_ready` returns to 1.
- R5: While sending, an `sr_done` with the request active aborts the write. The block takes `sr_rx_data` as the type of a new inbound frame: `sr_dir_out`=0, `tip_n`=0, `ack`=1. The packet stays pending (`tx_ready`=0) and is later resent from index 0.
- R6: In idle, an `sr_done` with the request active starts a receive. `sr_rx_data` becomes the frame type, `sr_dir_out`=0 and `tip_n`=0.
- R7: In idle, an `sr_done` with the request inactive is a false start: no frame and no byte output. If a send is pending, it starts INIT_SETTLE+1 cycles after the false start.
- R8: While receiving, each `sr_done` outputs the byte on `rx_data` with `rx_data_valid`=1, at payload index 0, 1, 2 and so on. If the request is still active, `ack` toggles. If the request is released, that byte ends the frame: `rx_frame_valid` pulses with `rx_type`, and `rx_len` equals the bytes received minus 1. The lines return to idle.
- R9: A frame holds at most RX_MAX bytes, the type byte included. If the RX_MAX-th byte arrives while the request is still active, the frame ends with `rx_overflow`=1 and `rx_len`=RX_MAX-1. A frame that ends normally has `rx_overflow`=0.
- R10: After a frame ends with a send pending, the send starts no sooner than TURN_SETTLE cycles later. If the request becomes active during that wait, no send starts until another frame has been received.
- R11: A packet is accepted only in a cycle with `tx_valid`=1 and `tx_ready`=1, and `tx_len` must be 1 or more. A `tx_valid` while `tx_ready`=0 is ignored: it starts no extra send and does not alter the send in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| peer_req_n | input | 1 | Peer request, active low, asynchronous |
| tip_n | output | 1 | Transfer in progress, active low |
| ack | output | 1 | Byte acknowledge, toggled per byte |
| sr_dir_out | output | 1 | Shift direction, 1 = output |
| sr_load | output | 1 | Load pulse for the outbound byte |
| sr_load_data | output | 8 | Byte to load |
| sr_done | input | 1 | Byte-shifted pulse |
| sr_rx_data | input | 8 | Byte shifted in |
| tx_valid | input | 1 | Outbound packet offered |
| tx_ready | output | 1 | Packet can be accepted |
| tx_len | input | LW | Total packet bytes including type |
| tx_idx | output | LW | Index of the byte wanted |
| tx_data | input | 8 | Byte at `tx_idx` |
| rx_data_valid | output | 1 | Inbound payload byte strobe |
| rx_data_idx | output | CW | Payload index |
| rx_data | output | 8 | Payload byte |
| rx_frame_valid | output | 1 | Frame complete pulse |
| rx_type | output | 8 | Frame type byte |
| rx_len | output | CW | Payload byte count |
| rx_overflow | output | 1 | Frame cut at capacity |

## Verification
A wrong state shows at once on the handshake pins. A controller stuck in receive keeps `tip_n` low after the peer lets go. A missed abort leaves `sr_dir_out` high, with `sr_load` firing in the cycle after the peer's byte. Length tracking errors show up one done pulse late: the frame pulse arrives early or never, or `sr_load` fires one index past `tx_len`. Timer errors appear as a resend that comes too early or not at all, measured in cycles from the frame pulse.

// File: rtl/hslink_pkg.sv
package hslink_pkg;
  typedef enum logic [1:0] {LS_INIT, LS_IDLE, LS_RECV, LS_SEND} link_state_e;
  typedef enum logic [1:0] {IS_TIP, IS_TOGGLE, IS_UNTIP, IS_IDLE} init_step_e;
endpackage

// File: rtl/hslink_sync.sv
module hslink_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d_async};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hslink_timer.sv
module hslink_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clear,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= RST_VAL;
    else if (clear)      cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && load_val != '0) |=> busy); // R10
endmodule

// File: rtl/hslink_ctrl.sv
module hslink_ctrl
  import hslink_pkg::*;
#(
  parameter int INIT_SETTLE = 37500,
  parameter int TURN_SETTLE = 375000,
  parameter int RX_MAX      = 256,
  parameter int TX_MAX      = 256,
  parameter int SYNC_STAGES = 2,
  localparam int LW = $clog2(TX_MAX + 1),
  localparam int CW = $clog2(RX_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          peer_req_n,
  output logic          tip_n,
  output logic          ack,
  output logic          sr_dir_out,
  output logic          sr_load,
  output logic [7:0]    sr_load_data,
  input  logic          sr_done,
  input  logic [7:0]    sr_rx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [LW-1:0] tx_len,
  output logic [LW-1:0] tx_idx,
  input  logic [7:0]    tx_data,
  output logic          rx_data_valid,
  output logic [CW-1:0] rx_data_idx,
  output logic [7:0]    rx_data,
  output logic          rx_frame_valid,
  output logic [7:0]    rx_type,
  output logic [CW-1:0] rx_len,
  output logic          rx_overflow
);
  localparam int MAXD = (INIT_SETTLE > TURN_SETTLE) ? INIT_SETTLE : TURN_SETTLE;
  localparam int TW   = $clog2(MAXD + 1);
  localparam logic [TW-1:0] INIT_C = TW'(INIT_SETTLE);
  localparam logic [TW-1:0] TURN_C = TW'(TURN_SETTLE);
  localparam logic [CW-1:0] RXMAX_C = CW'(RX_MAX);

  function automatic logic tx_finished(input logic [LW-1:0] sent_n, input logic [LW-1:0] len);
    return sent_n >= len;
  endfunction

  function automatic logic [CW-1:0] frame_len(input logic [CW-1:0] cnt);
    return cnt - CW'(1);
  endfunction

  function automatic logic buffer_full(input logic [CW-1:0] cnt);
    return cnt >= RXMAX_C;
  endfunction

  link_state_e  state_q;
  init_step_e   step_q;
  logic         pend_q;
  logic [LW-1:0] len_q, sent_q;
  logic [CW-1:0] rx_cnt;
  logic [7:0]   rx_type_q;

  logic req_sync, req_act;
  logic tmr_load, tmr_clear, tmr_busy;
  logic [TW-1:0] tmr_val;

  hslink_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(peer_req_n), .q(req_sync));

  assign req_act = !req_sync;

  // named internal events
  logic ev_accept, ev_init_step, ev_rx_start, ev_abort, ev_false;
  logic ev_tx_start, ev_tx_byte, ev_tx_last, ev_rx_byte, ev_rx_end, rx_full;
  logic [LW-1:0] sent_n;
  logic [CW-1:0] rx_cnt_n;

  assign tx_ready     = (state_q != LS_INIT) && !pend_q;
  assign ev_accept    = tx_valid && tx_ready;
  assign ev_init_step = (state_q == LS_INIT) && !tmr_busy;
  assign ev_rx_start  = sr_done && req_act && (state_q == LS_IDLE || state_q == LS_SEND);
  assign ev_abort     = ev_rx_start && (state_q == LS_SEND);
  assign ev_false     = sr_done && !req_act && (state_q == LS_IDLE);
  assign ev_tx_start  = (state_q == LS_IDLE) && !sr_done && pend_q && !tmr_busy && !req_act;
  assign ev_tx_byte   = (state_q == LS_SEND) && sr_done && !req_act;
  assign sent_n       = sent_q + LW'(1);
  assign ev_tx_last   = ev_tx_byte && tx_finished(sent_n, len_q);
  assign ev_rx_byte   = (state_q == LS_RECV) && sr_done;
  assign rx_cnt_n     = rx_cnt + CW'(1);
  assign rx_full      = buffer_full(rx_cnt_n);
  assign ev_rx_end    = ev_rx_byte && (!req_act || rx_full);

  assign tmr_load  = (ev_init_step && step_q != IS_IDLE) || (pend_q && (ev_false || ev_rx_end));
  assign tmr_val   = ev_rx_end ? TURN_C : INIT_C;
  assign tmr_clear = (state_q == LS_IDLE) && tmr_busy && req_act && !sr_done;

  hslink_timer #(.W(TW), .RST_VAL(INIT_C)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .clear(tmr_clear), .busy(tmr_busy));

  assign sr_load_data = tx_data;
  assign rx_type      = rx_type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_INIT;     step_q <= IS_TIP;
      tip_n <= 1'b1;          ack <= 1'b1;
      sr_dir_out <= 1'b0;     sr_load <= 1'b0;
      tx_idx <= '0;           sent_q <= '0;
      len_q <= '0;            pend_q <= 1'b0;
      rx_cnt <= '0;           rx_type_q <= '0;
      rx_data_valid <= 1'b0;  rx_data_idx <= '0;
      rx_data <= '0;          rx_frame_valid <= 1'b0;
      rx_len <= '0;           rx_overflow <= 1'b0;
    end else begin
      sr_load        <= 1'b0;
      rx_data_valid  <= 1'b0;
      rx_frame_valid <= 1'b0;
      if (ev_accept) begin
        pend_q <= 1'b1;
        len_q  <= tx_len;
      end
      if (ev_rx_start) begin
        rx_type_q  <= sr_rx_data;
        rx_cnt     <= CW'(1);
        tip_n      <= 1'b0;
        ack        <= 1'b1;
        sr_dir_out <= 1'b0;
        sent_q     <= '0;
        state_q    <= LS_RECV;
      end else begin
        unique case (state_q)
          LS_INIT: if (ev_init_step) begin
            unique case (step_q)
              IS_TIP:    begin tip_n <= 1'b0; step_q <= IS_TOGGLE; end
              IS_TOGGLE: begin ack <= ~ack;   step_q <= IS_UNTIP;  end
              IS_UNTIP:  begin tip_n <= 1'b1; step_q <= IS_IDLE;   end
              IS_IDLE:   begin tip_n <= 1'b1; ack <= 1'b1; state_q <= LS_IDLE; end
            endcase
          end
          LS_IDLE: if (ev_tx_start) begin
            sr_dir_out <= 1'b1;
            sr_load    <= 1'b1;
            tx_idx     <= '0;
            sent_q     <= '0;
            ack        <= 1'b1;
            tip_n      <= 1'b0;
            state_q    <= LS_SEND;
          end
          LS_SEND: if (ev_tx_byte) begin
            if (ev_tx_last) begin
              sr_dir_out <= 1'b0;
              tip_n      <= 1'b1;
              ack        <= 1'b1;
              pend_q     <= 1'b0;
              state_q    <= LS_IDLE;
            end else begin
              sr_load <= 1'b1;
              tx_idx  <= sent_n;
              sent_q  <= sent_n;
              ack     <= ~ack;
            end
          end
          LS_RECV: if (ev_rx_byte) begin
            rx_data_valid <= 1'b1;
            rx_data       <= sr_rx_data;
            rx_data_idx   <= rx_cnt - CW'(1);
            rx_cnt        <= rx_cnt_n;
            if (ev_rx_end) begin
              tip_n          <= 1'b1;
              ack            <= 1'b1;
              rx_frame_valid <= 1'b1;
              rx_len         <= frame_len(rx_cnt_n);
              rx_overflow    <= req_act && rx_full;
              state_q        <= LS_IDLE;
            end else begin
              ack <= ~ack;
            end
          end
          default: state_q <= LS_IDLE;
        endcase
      end
    end
  end

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_INIT) |-> (!rx_frame_valid && !sr_load && !rx_data_valid)); // R1
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_IDLE) |-> (tip_n && ack)); // R2
  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_dir_out) |-> !$past(req_act)); // R3
  AST_SEND_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_SEND) |-> (sr_dir_out && !tip_n)); // R4
  AST_ABORT_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (state_q == LS_RECV && !sr_dir_out && !tx_ready)); // R5
  AST_RECV_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_RECV) |-> (!tip_n && !sr_dir_out)); // R6
  AST_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_valid |-> (state_q == LS_IDLE && tip_n)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RXMAX_C); // R9
  AST_TX_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (tx_len != '0)); // R11
endmodule

// File: tb/hslink_ctrl_bench.sv
module hslink_ctrl_bench;
  localparam int INIT = 20;
  localparam int TURN = 120;
  localparam int RXM  = 8;
  localparam int TXM  = 16;
  localparam int LW = $clog2(TXM + 1);
  localparam int CW = $clog2(RXM + 1);

  logic clk = 1'b0, rst_n = 1'b0, peer_req_n = 1'b1;
  logic tip_n, ack, sr_dir_out, sr_load, sr_done = 1'b0, tx_valid = 1'b0, tx_ready;
  logic [7:0] sr_load_data, sr_rx_data = '0, tx_data, rx_data, rx_type;
  logic [LW-1:0] tx_len = '0, tx_idx;
  logic rx_data_valid, rx_frame_valid, rx_overflow;
  logic [CW-1:0] rx_data_idx, rx_len;
  logic [7:0] tx_mem [TXM];
  int total = 0, bad = 0;

  always #2 clk = ~clk;
  assign tx_data = tx_mem[tx_idx[3:0]];

  hslink_ctrl #(.INIT_SETTLE(INIT), .TURN_SETTLE(TURN), .RX_MAX(RXM), .TX_MAX(TXM)) u_hslink_ctrl (
    .clk(clk), .rst_n(rst_n), .peer_req_n(peer_req_n), .tip_n(tip_n), .ack(ack),
    .sr_dir_out(sr_dir_out), .sr_load(sr_load), .sr_load_data(sr_load_data),
    .sr_done(sr_done), .sr_rx_data(sr_rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_len(tx_len), .tx_idx(tx_idx), .tx_data(tx_data), .rx_data_valid(rx_data_valid),
    .rx_data_idx(rx_data_idx), .rx_data(rx_data), .rx_frame_valid(rx_frame_valid),
    .rx_type(rx_type), .rx_len(rx_len), .rx_overflow(rx_overflow));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_done(input logic [7:0] d);
    @(negedge clk); sr_done = 1'b1; sr_rx_data = d;
    @(negedge clk); sr_done = 1'b0;
  endtask

  task automatic set_req(input logic v);
    @(negedge clk); peer_req_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_load(input int maxc, output int c);
    c = 0;
    while (!sr_load && c < maxc) begin @(negedge clk); c++; end
  endtask

  task automatic offer(input int len);
    @(negedge clk); tx_valid = 1'b1; tx_len = LW'(len);
    chk(tx_ready == 1'b1, "R11 ready before accept", int'(tx_ready), 1);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic finish_send(input int len);
    for (int k = 1; k < len; k++) begin
      pulse_done(8'h00);
      chk(sr_load && tx_idx == LW'(k), "R4 next byte index", int'(tx_idx), k);
      chk(sr_load_data == tx_mem[k], "R4 next byte data", int'(sr_load_data), int'(tx_mem[k]));
    end
    pulse_done(8'h00);
    chk(!sr_dir_out && tip_n && ack && tx_ready, "R4 send complete lines",
        int'({sr_dir_out, tip_n, ack, tx_ready}), 4'b0111);
  endtask

  // start a send, abort it at the first byte, and finish a one-payload frame
  task automatic abort_frame(input int len, input logic [7:0] typ, input logic [7:0] pay);
    int c;
    offer(len);
    wait_load(50, c);
    chk(sr_load && tx_idx == '0, "R3 send start", int'(sr_load), 1);
    set_req(1'b0);
    pulse_done(typ);
    chk(!sr_dir_out && !tip_n && ack && !tx_ready && !sr_load, "R5 abort to receive",
        int'({sr_dir_out, tip_n, ack, tx_ready, sr_load}), 5'b00100);
    set_req(1'b1);
    pulse_done(pay);
    chk(rx_frame_valid && rx_type == typ && rx_len == CW'(1) && rx_data == pay,
        "R5 aborted frame contents", int'(rx_type), int'(typ));
  endtask

  task automatic t_reset_init();
    int t0, t1, t2;
    chk(tip_n && ack && !tx_ready && !sr_dir_out, "R1 reset state",
        int'({tip_n, ack, tx_ready, sr_dir_out}), 4'b1100);
    @(negedge clk); rst_n = 1'b1;
    peer_req_n = 1'b0;
    repeat (3) @(negedge clk);
    pulse_done(8'hEE);
    chk(!rx_frame_valid && !rx_data_valid && tip_n && !tx_ready, "R1 done ignored in start-up",
        int'({rx_frame_valid, rx_data_valid}), 0);
    peer_req_n = 1'b1;
    t0 = 0; while (tip_n && t0 < 200) begin @(negedge clk); t0++; end
    chk(!tip_n && ack, "R1 step tip asserted", int'(tip_n), 0);
    t1 = 0; while (ack && t1 < 200) begin @(negedge clk); t1++; end
    chk(!ack && !tip_n && t1 >= INIT, "R1 ack toggle after settle", t1, INIT);
    t2 = 0; while (!tip_n && t2 < 200) begin @(negedge clk); t2++; end
    chk(tip_n && t2 >= INIT && !tx_ready, "R1 tip released after settle", t2, INIT);
    t2 = 0; while (!ack && t2 < 200) begin @(negedge clk); t2++; end
    chk(ack && tip_n && t2 >= INIT, "R1 back to idle after settle", t2, INIT);
    @(negedge clk);
    chk(tx_ready && tip_n && ack, "R2 idle lines and ready", int'({tx_ready, tip_n, ack}), 3'b111);
  endtask

  task automatic t_send();
    int c;
    tx_mem[0] = 8'hA1; tx_mem[1] = 8'h10; tx_mem[2] = 8'h20;
    offer(3);
    chk(!tx_ready, "R11 ready drops after accept", int'(tx_ready), 0);
    wait_load(50, c);
    chk(sr_load && tx_idx == '0 && sr_load_data == 8'hA1, "R3 first byte load", int'(sr_load_data), 8'hA1);
    chk(sr_dir_out && !tip_n && ack, "R3 start lines", int'({sr_dir_out, tip_n, ack}), 3'b101);
    tx_valid = 1'b1; tx_len = LW'(2);
    pulse_done(8'h00);
    chk(sr_load && tx_idx == LW'(1) && sr_load_data == 8'h10 && !ack, "R4 byte1 load and ack toggle",
        int'(tx_idx), 1);
    tx_valid = 1'b0;
    pulse_done(8'h00);
    chk(sr_load && tx_idx == LW'(2) && ack, "R4 byte2 load and ack toggle", int'(tx_idx), 2);
    pulse_done(8'h00);
    chk(!sr_dir_out && tip_n && ack && tx_ready && !sr_load, "R4 end after tx_len bytes",
        int'({sr_dir_out, tip_n, ack, tx_ready}), 4'b0111);
    wait_load(30, c);
    chk(!sr_load, "R11 offer while busy ignored", int'(sr_load), 0);
  endtask

  task automatic t_receive();
    set_req(1'b0);
    pulse_done(8'h5A);
    chk(!tip_n && !sr_dir_out && !rx_frame_valid, "R6 receive start", int'(tip_n), 0);
    pulse_done(8'h01);
    chk(rx_data_valid && rx_data_idx == '0 && rx_data == 8'h01 && !ack, "R8 payload0 and ack toggle",
        int'(rx_data_idx), 0);
    pulse_done(8'h02);
    chk(rx_data_valid && rx_data_idx == CW'(1) && ack && !rx_frame_valid, "R8 payload1",
        int'(rx_data_idx), 1);
    set_req(1'b1);
    pulse_done(8'h03);
    chk(rx_data_valid && rx_data_idx == CW'(2) && rx_data == 8'h03, "R8 last payload", int'(rx_data), 3);
    chk(rx_frame_valid && rx_type == 8'h5A && rx_len == CW'(3) && !rx_overflow, "R8 frame summary",
        int'(rx_len), 3);
    chk(tip_n && ack, "R8 lines idle after frame", int'({tip_n, ack}), 3);
  endtask

  task automatic t_overflow();
    set_req(1'b0);
    pulse_done(8'h77);
    for (int k = 0; k < RXM - 2; k++) begin
      pulse_done(8'(k));
      chk(!rx_frame_valid, "R9 no early end", int'(rx_frame_valid), 0);
    end
    pulse_done(8'hFF);
    chk(rx_frame_valid && rx_overflow && rx_len == CW'(RXM - 1), "R9 overflow end",
        int'(rx_len), RXM - 1);
    chk(tip_n, "R9 lines idle after overflow", int'(tip_n), 1);
    set_req(1'b1);
  endtask

  task automatic t_false_start();
    pulse_done(8'h99);
    chk(!rx_frame_valid && !rx_data_valid && tip_n && !sr_dir_out, "R7 false start no frame",
        int'({rx_frame_valid, rx_data_valid, tip_n}), 3'b001);
  endtask

  task automatic t_abort_retry();
    int c;
    tx_mem[0] = 8'hC0; tx_mem[1] = 8'hC1; tx_mem[2] = 8'hC2; tx_mem[3] = 8'hC3;
    offer(4);
    wait_load(50, c);
    pulse_done(8'h00);
    chk(sr_load && tx_idx == LW'(1), "R4 byte1 before abort", int'(tx_idx), 1);
    set_req(1'b0);
    pulse_done(8'h33);
    chk(!sr_dir_out && !tip_n && ack && !tx_ready && !sr_load, "R5 mid-write abort",
        int'({sr_dir_out, tip_n, ack, tx_ready}), 4'b0010);
    set_req(1'b1);
    pulse_done(8'h44);
    chk(rx_frame_valid && rx_type == 8'h33 && rx_len == CW'(1), "R5 abort frame", int'(rx_type), 8'h33);
    wait_load(TURN + 50, c);
    chk(sr_load && c >= TURN, "R10 turnaround delay", c, TURN);
    chk(tx_idx == '0 && sr_load_data == 8'hC0, "R5 retry from byte 0", int'(tx_idx), 0);
    finish_send(4);
  endtask

  task automatic t_false_pending();
    int c;
    tx_mem[0] = 8'hD0; tx_mem[1] = 8'hD1;
    abort_frame(2, 8'h21, 8'h22);
    repeat (10) @(negedge clk);
    pulse_done(8'h00);
    chk(!rx_frame_valid && tip_n, "R7 false start during wait", int'(rx_frame_valid), 0);
    wait_load(TURN + 50, c);
    chk(sr_load && c >= INIT && c < TURN - 20, "R7 restart after short settle", c, INIT + 1);
    finish_send(2);
  endtask

  task automatic t_wait_cancel();
    int c;
    tx_mem[0] = 8'hE0; tx_mem[1] = 8'hE1;
    abort_frame(2, 8'h31, 8'h32);
    repeat (5) @(negedge clk);
    set_req(1'b0);
    wait_load(TURN + 30, c);
    chk(!sr_load && tip_n, "R10 request during wait blocks send", int'(sr_load), 0);
    pulse_done(8'h61);
    chk(!tip_n && !sr_dir_out, "R10 receive taken instead", int'(tip_n), 0);
    set_req(1'b1);
    pulse_done(8'h62);
    chk(rx_frame_valid && rx_type == 8'h61, "R10 frame before resend", int'(rx_type), 8'h61);
    wait_load(TURN + 50, c);
    chk(sr_load && c >= TURN && tx_idx == '0, "R10 resend after new wait", c, TURN);
    finish_send(2);
  endtask

  initial begin
    for (int i = 0; i < TXM; i++) tx_mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    t_reset_init();
    t_send();
    t_receive();
    t_overflow();
    t_false_start();
    t_abort_retry();
    t_false_pending();
    t_wait_cancel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule